// File: doc/BRIEF.md
# Endian-Selectable Bus Byte Steering

This block joins a 16-bit host data bus to a byte-wide transmit path and a byte-wide receive path. A host write of a whole word is split into two bytes that leave one after another on the transmit byte stream. A host read of a whole word gathers two bytes from the receive byte stream and returns them packed into one word. Single-byte accesses move one byte, and the bus half that carries it depends on the low address bit.

A strap input chooses the host convention. When it is high, the low half of the bus (bits 7:0) is first in the byte stream, and a single-byte access at an even address uses the low half. When it is low, both mappings are reversed. The strap only changes which data lanes are used. Handshake timing is the same under either setting. The strap is captured while reset is asserted and holds its value until the next reset.

The host side uses a request/ready handshake with a one-cycle read response pulse. Both byte sides use valid/ready.

Top module: `bus_lane_steer`

## Requirements
- R1: With the strap latched high, a word write emits bits 7:0 first and bits 15:8 second on the transmit stream.
- R2: With the strap latched low, a word write emits bits 15:8 first and bits 7:0 second.
- R3: A byte write emits exactly one byte. With the strap high it is taken from bits 7:0 at address 0 and from bits 15:8 at address 1. With the strap low it is taken from bits 15:8 at address 0 and from bits 7:0 at address 1. The other half of the write data has no effect.
- R4: A word read places the first received byte in bits 7:0 and the second in bits 15:8 when the strap is high, and the reverse when it is low. The response pulse comes only after the second byte.
- R5: A byte read returns the received byte on the half chosen by the R3 mapping, and the other half reads as zero.
- R6: `host_req_ready` stays low from the cycle after a request is accepted until every byte of that transfer has been accepted downstream or received upstream. A transmit byte stays stable while it is held back.
- R7: With an always-ready sink and an always-valid source, a word transfer returns `host_req_ready` on the third falling edge after acceptance and a byte transfer on the second, under either strap value.
- R8: The strap is sampled only during reset. A change made outside reset has no effect until the next reset.
- R9: Synchronous active-high reset drops any partly packed word, discards any transmit bytes not yet sent, and leaves the block idle with `host_req_ready` high.
- R10: The read response is a single-cycle pulse in the cycle right after the edge that takes the last byte, with the data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the strap |
| order_sel | input | 1 | Byte-order strap: 1 = low half first, 0 = high half first |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Block can accept a request |
| host_req_write | input | 1 | 1 = write (transmit), 0 = read (receive) |
| host_req_wide | input | 1 | 1 = 16-bit transfer, 0 = single byte |
| host_req_addr | input | 1 | Byte address bit for single-byte accesses |
| host_wdata | input | 16 | Host write data |
| host_rsp_valid | output | 1 | Read response pulse |
| host_rdata | output | 16 | Read response data |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmit sink takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Block takes a receive byte |
| rx_data | input | 8 | Receive byte |

## Verification
The bench runs both strap values through word and byte transfers in both directions. If the two bus halves were swapped, or the address bit were not inverted under the low strap, bytes would come out in the wrong order or on the wrong half, and the scoreboard would report it. A stalling transmit sink and a receive source with gaps show whether a design releases the host early or drops a held byte. Fixed handshake latencies under both straps catch a design whose timing depends on the strap. Changing the strap outside reset, and resetting in the middle of a transfer, expose a design that follows the live strap, leaks a stale byte after reset, or keeps a leftover transmit byte.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Host operation kind, encoded as {write, wide}
    typedef enum logic [1:0] {
        OP_RD_BYTE = 2'b00,
        OP_RD_WORD = 2'b01,
        OP_WR_BYTE = 2'b10,
        OP_WR_WORD = 2'b11
    } host_op_e;

    // Bus lane that carries stream position 'pos' (also the lane of a
    // single-byte access at byte address 'pos').
    function automatic int unsigned stream_lane(input logic low_first,
                                                 input int unsigned pos,
                                                 input int unsigned lanes);
        return low_first ? pos : (lanes - 1 - pos);
    endfunction

    function automatic int unsigned idx_width(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    function automatic bit op_is_write(input host_op_e op);
        return (op == OP_WR_BYTE) || (op == OP_WR_WORD);
    endfunction

    function automatic bit op_is_wide(input host_op_e op);
        return (op == OP_RD_WORD) || (op == OP_WR_WORD);
    endfunction

endpackage

// File: rtl/lane_order_map.sv
`timescale 1ns/1ps
module lane_order_map
    import lane_pkg::*;
#(
    parameter int unsigned LANES = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic                         low_first,
    input  logic [IDX_W-1:0]             byte_addr,
    output logic [LANES-1:0][IDX_W-1:0]  pos_lane,
    output logic [IDX_W-1:0]             single_lane
);

    // One lane index per position in the byte stream
    for (genvar g = 0; g < LANES; g++) begin : g_pos
        assign pos_lane[g] = IDX_W'(stream_lane(low_first, g, LANES));
    end

    // A single-byte access follows the same lane order as the stream
    assign single_lane = IDX_W'(stream_lane(low_first, int'(byte_addr), LANES));

endmodule

// File: rtl/byte_splitter.sv
`timescale 1ns/1ps
module byte_splitter
    import lane_pkg::*;
#(
    parameter int unsigned LANES = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         wide,
    input  logic [IDX_W-1:0]             single_lane,
    input  logic [LANES-1:0][IDX_W-1:0]  pos_lane,
    input  logic [LANES*BYTE_W-1:0]      wdata,
    output logic                         tx_valid,
    input  logic                         tx_ready,
    output byte_t                        tx_data,
    output logic                         busy
);

    localparam int unsigned CNT_W = $clog2(LANES + 1);

    byte_t [LANES-1:0] lane_b;
    byte_t [LANES-1:0] slot_d;
    byte_t [LANES-1:0] slot_q;
    logic  [CNT_W-1:0] left_q;
    logic  [IDX_W-1:0] rd_q;
    logic              beat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = wdata[g*BYTE_W +: BYTE_W];
    end

    // Reorder the host word into stream order at acceptance
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (wide) begin
                slot_d[k] = lane_b[pos_lane[k]];
            end else if (k == 0) begin
                slot_d[k] = lane_b[single_lane];
            end else begin
                slot_d[k] = '0;
            end
        end
    end

    assign tx_valid = (left_q != '0);
    assign tx_data  = slot_q[rd_q];
    assign beat     = tx_valid && tx_ready;
    assign busy     = tx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            left_q <= '0;
            rd_q   <= '0;
        end else if (start) begin
            slot_q <= slot_d;
            left_q <= wide ? CNT_W'(LANES) : CNT_W'(1);
            rd_q   <= '0;
        end else if (beat) begin
            left_q <= left_q - CNT_W'(1);
            rd_q   <= rd_q + IDX_W'(1);
        end
    end

endmodule

// File: rtl/byte_packer.sv
`timescale 1ns/1ps
module byte_packer
    import lane_pkg::*;
#(
    parameter int unsigned LANES = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         wide,
    input  logic [IDX_W-1:0]             single_lane,
    input  logic [LANES-1:0][IDX_W-1:0]  pos_lane,
    input  logic                         rx_valid,
    output logic                         rx_ready,
    input  byte_t                        rx_data,
    output logic [LANES*BYTE_W-1:0]      word,
    output logic                         done,
    output logic                         busy
);

    localparam int unsigned CNT_W = $clog2(LANES + 1);

    byte_t [LANES-1:0] word_q;
    logic  [CNT_W-1:0] left_q;
    logic  [IDX_W-1:0] wr_q;
    logic  [IDX_W-1:0] single_q;
    logic              wide_q;
    logic              done_q;
    logic  [IDX_W-1:0] target;
    logic              beat;

    assign rx_ready = (left_q != '0);
    assign beat     = rx_valid && rx_ready;
    assign target   = wide_q ? pos_lane[wr_q] : single_q;
    assign busy     = rx_ready;
    assign done     = done_q;

    for (genvar g = 0; g < LANES; g++) begin : g_word
        assign word[g*BYTE_W +: BYTE_W] = word_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            left_q   <= '0;
            wr_q     <= '0;
            single_q <= '0;
            wide_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                word_q   <= '0;
                left_q   <= wide ? CNT_W'(LANES) : CNT_W'(1);
                wr_q     <= '0;
                single_q <= single_lane;
                wide_q   <= wide;
            end else if (beat) begin
                word_q[target] <= rx_data;
                left_q         <= left_q - CNT_W'(1);
                wr_q           <= wr_q + IDX_W'(1);
                done_q         <= (left_q == CNT_W'(1));
            end
        end
    end

endmodule

// File: rtl/bus_lane_steer.sv
`timescale 1ns/1ps
module bus_lane_steer
    import lane_pkg::*;
#(
    parameter  int unsigned DATA_W = 16,
    localparam int unsigned LANES  = DATA_W / BYTE_W,
    localparam int unsigned IDX_W  = idx_width(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              order_sel,
    input  logic              host_req_valid,
    output logic              host_req_ready,
    input  logic              host_req_write,
    input  logic              host_req_wide,
    input  logic [IDX_W-1:0]  host_req_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rsp_valid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_data
);

    logic                         low_first_q;
    logic [LANES-1:0][IDX_W-1:0]  pos_lane;
    logic [IDX_W-1:0]             single_lane;
    host_op_e                     op;
    logic                         accept;
    logic                         start_tx;
    logic                         start_rx;
    logic                         tx_busy;
    logic                         rx_busy;

    // Strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            low_first_q <= order_sel;
        end
    end

    assign op             = host_op_e'({host_req_write, host_req_wide});
    assign host_req_ready = !tx_busy && !rx_busy;
    assign accept         = host_req_valid && host_req_ready;
    assign start_tx       = accept && op_is_write(op);
    assign start_rx       = accept && !op_is_write(op);

    lane_order_map #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) map_i (
        .low_first   (low_first_q),
        .byte_addr   (host_req_addr),
        .pos_lane    (pos_lane),
        .single_lane (single_lane)
    );

    byte_splitter #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) split_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start_tx),
        .wide        (op_is_wide(op)),
        .single_lane (single_lane),
        .pos_lane    (pos_lane),
        .wdata       (host_wdata),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .busy        (tx_busy)
    );

    byte_packer #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) pack_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start_rx),
        .wide        (op_is_wide(op)),
        .single_lane (single_lane),
        .pos_lane    (pos_lane),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_data     (rx_data),
        .word        (host_rdata),
        .done        (host_rsp_valid),
        .busy        (rx_busy)
    );

endmodule

// File: rtl/bus_lane_steer_checker.sv
`timescale 1ns/1ps
module bus_lane_steer_checker (
    input logic       clk,
    input logic       rst,
    input logic       strap_q,
    input logic       host_req_ready,
    input logic       host_rsp_valid,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       rx_valid,
    input logic       rx_ready
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R6: a held transmit byte stays put
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6: host side blocked while a transfer is in flight
    p_ready_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid || rx_ready) |-> !host_req_ready);

    // R6: never both directions at once
    p_one_dir_r6: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_ready));

    // R10: response is a single-cycle pulse
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        host_rsp_valid |=> !host_rsp_valid);

    // R4: response only right after a received byte
    p_rsp_after_byte_r4: assert property (@(posedge clk) disable iff (rst)
        host_rsp_valid |-> $past(rx_valid && rx_ready));

    // R8: strap latch moves only in reset
    p_strap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(strap_q));

    // R9: idle right after reset
    p_idle_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!tx_valid && !rx_ready && !host_rsp_valid && host_req_ready));

endmodule

bind bus_lane_steer bus_lane_steer_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .strap_q        (low_first_q),
    .host_req_ready (host_req_ready),
    .host_rsp_valid (host_rsp_valid),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_data        (tx_data),
    .rx_valid       (rx_valid),
    .rx_ready       (rx_ready)
);

// File: tb/bus_lane_steer_tb_top.sv
`timescale 1ns/1ps
module bus_lane_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        order_sel = 1'b1;
    logic        host_req_valid = 1'b0;
    logic        host_req_ready;
    logic        host_req_write = 1'b0;
    logic        host_req_wide = 1'b0;
    logic [0:0]  host_req_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_rsp_valid;
    logic [15:0] host_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    // Scoreboard state
    logic [7:0]  exp_tx[$];
    string       tx_tag[$];
    logic [15:0] exp_rsp[$];
    string       rsp_tag[$];
    logic [7:0]  rx_src[$];

    bit  eff_sel = 1'b1;
    bit  sink_stall = 1'b0;
    bit  sink_block = 1'b0;
    bit  src_gaps = 1'b0;
    bit  rx_taken = 1'b0;
    int  cyc = 0;
    bit  hold_pend = 1'b0;
    logic [7:0] hold_byte = '0;

    always #5 clk = ~clk;

    bus_lane_steer dut_i (
        .clk            (clk),
        .rst            (rst),
        .order_sel      (order_sel),
        .host_req_valid (host_req_valid),
        .host_req_ready (host_req_ready),
        .host_req_write (host_req_write),
        .host_req_wide  (host_req_wide),
        .host_req_addr  (host_req_addr),
        .host_wdata     (host_wdata),
        .host_rsp_valid (host_rsp_valid),
        .host_rdata     (host_rdata),
        .tx_valid       (tx_valid),
        .tx_ready       (tx_ready),
        .tx_data        (tx_data),
        .rx_valid       (rx_valid),
        .rx_ready       (rx_ready),
        .rx_data        (rx_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Transmit sink
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = sink_block ? 1'b0 : (sink_stall ? ((cyc % 3) == 2) : 1'b1);
    end

    // Receive source
    always @(posedge clk) begin
        #1;
        if (rst) begin
            rx_valid = 1'b0;
            rx_taken = 1'b0;
        end else begin
            if (rx_taken && rx_src.size() > 0) void'(rx_src.pop_front());
            rx_taken = 1'b0;
            rx_valid = (rx_src.size() > 0) && !(src_gaps && (cyc % 2 == 0));
            rx_data  = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
        end
    end

    // Monitor: compare outputs against the scoreboard away from the edge
    always @(negedge clk) begin
        if (rst) begin
            hold_pend = 1'b0;
        end else begin
            rx_taken = rx_valid && rx_ready;
            if (hold_pend) begin
                chk(tx_valid && (tx_data == hold_byte), "R6", "held tx byte", tx_data, hold_byte);
            end
            hold_pend = tx_valid && !tx_ready;
            hold_byte = tx_data;
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    chk(1'b0, "R9", "unexpected tx byte", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_tx.pop_front();
                    t = tx_tag.pop_front();
                    chk(tx_data == e, t, "tx byte", tx_data, e);
                end
            end
            if (host_rsp_valid) begin
                if (exp_rsp.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", host_rdata, 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_rsp.pop_front();
                    t = rsp_tag.pop_front();
                    chk(host_rdata == e, t, "read word", host_rdata, e);
                end
            end
        end
    end

    task automatic do_reset(input bit sel);
        @(posedge clk);
        #1;
        rst = 1'b1;
        order_sel = sel;
        host_req_valid = 1'b0;
        exp_tx.delete();
        tx_tag.delete();
        exp_rsp.delete();
        rsp_tag.delete();
        rx_src.delete();
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        eff_sel = sel;
        @(negedge clk);
        chk(host_req_ready == 1'b1, "R9", "ready after reset", host_req_ready, 1);
        chk(!tx_valid && !rx_ready && !host_rsp_valid, "R9", "idle outputs after reset",
            {tx_valid, rx_ready, host_rsp_valid}, 0);
    endtask

    task automatic host_issue(input bit wr, input bit wd, input bit a, input logic [15:0] d);
        @(posedge clk);
        #1;
        host_req_valid = 1'b1;
        host_req_write = wr;
        host_req_wide  = wd;
        host_req_addr  = a;
        host_wdata     = d;
        do @(negedge clk); while (!host_req_ready);
        @(posedge clk);
        #1;
        host_req_valid = 1'b0;
        host_wdata     = '0;
    endtask

    // Driver: pushes expected items, issues, measures handshake latency
    task automatic host_op(input bit wr, input bit wd, input bit a, input logic [15:0] d,
                           input logic [7:0] b0, input logic [7:0] b1, input string tag,
                           output int lat);
        if (wr) begin
            if (wd) begin
                exp_tx.push_back(eff_sel ? d[7:0] : d[15:8]);
                exp_tx.push_back(eff_sel ? d[15:8] : d[7:0]);
                tx_tag.push_back(tag);
                tx_tag.push_back(tag);
            end else begin
                exp_tx.push_back((eff_sel ^ a) ? d[7:0] : d[15:8]);
                tx_tag.push_back(tag);
            end
        end else begin
            if (wd) begin
                exp_rsp.push_back(eff_sel ? {b1, b0} : {b0, b1});
                rx_src.push_back(b0);
                rx_src.push_back(b1);
            end else begin
                exp_rsp.push_back((eff_sel ^ a) ? {8'h00, b0} : {b0, 8'h00});
                rx_src.push_back(b0);
            end
            rsp_tag.push_back(tag);
        end
        host_issue(wr, wd, a, d);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_req_ready);
    endtask

    task automatic settle(input string tag);
        repeat (2) @(negedge clk);
        chk(exp_tx.size() == 0 && exp_rsp.size() == 0, tag, "scoreboard drained",
            exp_tx.size() + exp_rsp.size(), 0);
    endtask

    task automatic strap_suite(input string tw, input string tnw);
        int lat;
        host_op(1, 1, 0, 16'hA55A, 0, 0, tw, lat);
        chk(lat == 3, "R7", "word write latency", lat, 3);
        host_op(1, 1, 0, 16'h1234, 0, 0, tw, lat);
        host_op(1, 0, 0, 16'h77C3, 0, 0, "R3", lat);
        chk(lat == 2, "R7", "byte write latency", lat, 2);
        host_op(1, 0, 1, 16'h77C3, 0, 0, "R3", lat);
        host_op(0, 1, 0, 0, 8'h3C, 8'hE1, "R4", lat);
        chk(lat == 3, "R7", "word read latency", lat, 3);
        host_op(0, 0, 0, 0, 8'h9D, 0, "R5", lat);
        chk(lat == 2, "R7", "byte read latency", lat, 2);
        host_op(0, 0, 1, 0, 8'h9D, 0, "R5", lat);
        settle(tnw);
    endtask

    initial begin
        int lat;
        chk(1'b1, "R9", "start", 0, 0);
        do_reset(1'b1);

        // Strap high: R1, R3, R4, R5, R7
        strap_suite("R1", "R1");

        // Backpressure and source gaps: R6, R10
        sink_stall = 1'b1;
        src_gaps   = 1'b1;
        host_op(1, 1, 0, 16'hC0DE, 0, 0, "R6", lat);
        chk(lat >= 3, "R6", "ready held low under stall", lat, 3);
        host_op(1, 1, 0, 16'h0FF0, 0, 0, "R6", lat);
        host_op(1, 0, 1, 16'h5AA5, 0, 0, "R6", lat);
        host_op(0, 1, 0, 0, 8'h81, 8'h7E, "R10", lat);
        chk(lat >= 3, "R6", "ready held low with gaps", lat, 3);
        host_op(0, 0, 0, 0, 8'h42, 0, "R10", lat);
        sink_stall = 1'b0;
        src_gaps   = 1'b0;
        settle("R6");

        // R8: strap change outside reset is ignored
        order_sel = 1'b0;
        host_op(1, 1, 0, 16'h1234, 0, 0, "R8", lat);
        host_op(0, 0, 0, 0, 8'hB7, 0, "R8", lat);
        settle("R8");

        // Strap low after reset: R2, R3, R4, R5, R7
        do_reset(1'b0);
        strap_suite("R2", "R2");

        // R9: reset in the middle of a word read
        rx_src.push_back(8'hAA);
        host_issue(0, 1, 0, 16'h0000);
        repeat (4) @(negedge clk);
        do_reset(1'b0);
        host_op(0, 0, 0, 0, 8'h5C, 0, "R9", lat);
        host_op(0, 1, 0, 0, 8'h11, 8'h22, "R9", lat);
        settle("R9");

        // R9: reset with transmit bytes pending
        sink_block = 1'b1;
        host_issue(1, 1, 0, 16'hBEEF);
        repeat (3) @(negedge clk);
        do_reset(1'b0);
        sink_block = 1'b0;
        repeat (6) @(negedge clk);
        chk(!tx_valid, "R9", "no stale tx byte", tx_valid, 0);
        host_op(1, 1, 0, 16'h4321, 0, 0, "R9", lat);
        settle("R9");

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule